// File: doc/BRIEF.md
# Segment Table Address Translator

This block maps a virtual address onto a physical address through an on-chip table of eight segment descriptors. The top three bits of the virtual address select a descriptor, and the remaining bits are an offset into that segment. Each descriptor holds a base, a limit, a valid flag and a read-only flag. The physical address is the selected base plus the offset. The lookup and every check run in a single combinational path, so a result is available in the same cycle as the request.

A lookup produces one of two results: a physical address, or one or more fault flags. A fault is raised when the segment is not valid, when the offset lies beyond the limit, or when a store targets a read-only segment. Software with supervisor rights loads descriptors through a write port, and each write takes effect at the next clock edge. A write attempted without supervisor rights is refused and flagged. Reset marks every descriptor as not valid.

Top module: `seg_xlate_top`

## Requirements
- R1: After a synchronous reset, every descriptor is not valid, so a lookup of any segment number raises `err_invalid`. Writes presented while `rst` is high have no effect.
- R2: The segment number is `xl_va[31:29]` and the offset is `xl_va[28:0]`, zero-extended. When no fault applies, `pa_ok` is 1 and `pa` equals the selected base plus the offset.
- R3: An offset strictly greater than the selected limit raises `err_limit` and clears `pa_ok`. An offset equal to the limit is allowed.
- R4: A lookup that hits a descriptor with the valid flag at 0 raises `err_invalid`. In that case `err_limit` and `err_prot` stay at 0, whatever the other conditions are.
- R5: A store (`xl_store`=1) to a valid descriptor whose read-only flag is 1 raises `err_prot`. A load from the same segment is not faulted for protection. When both apply, `err_limit` and `err_prot` are raised together.
- R6: A supervisor write (`wr_en`=1, `wr_priv`=1) replaces base, limit, valid flag and read-only flag of descriptor `wr_idx` at the next rising edge. A lookup in the same cycle as the write still sees the old contents.
- R7: A write with `wr_priv`=0 drives `wr_denied` to 1 in that cycle and leaves the table unchanged.
- R8: Whenever `pa_ok` is 0, `pa` is driven to all zeros.
- R9: The sum of base and offset wraps modulo 2 to the power of the physical address width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all valid flags |
| wr_en | input | 1 | Descriptor write request |
| wr_priv | input | 1 | Write is issued with supervisor rights |
| wr_idx | input | 3 | Descriptor to be written |
| wr_base | input | 32 | New base |
| wr_limit | input | 32 | New limit (largest allowed offset) |
| wr_valid | input | 1 | New valid flag |
| wr_ronly | input | 1 | New read-only flag |
| wr_denied | output | 1 | Write refused for lack of supervisor rights |
| xl_va | input | 32 | Virtual address to translate |
| xl_store | input | 1 | 1 for a store, 0 for a load |
| pa | output | 32 | Physical address, zero when faulted |
| pa_ok | output | 1 | Translation succeeded |
| err_limit | output | 1 | Offset beyond limit |
| err_invalid | output | 1 | Segment not valid |
| err_prot | output | 1 | Store to read-only segment |

## Verification
The bench builds the block with its default parameters: a 32-bit virtual address with 3 segment bits and a 32-bit physical address. With these values, a 29-bit offset can reach past a small limit, and a base near the top of the 32-bit range makes the sum wrap. All eight descriptors can be reached, so the reset sweep and the random writes cover the whole table. The limit equality boundary, the combined limit-and-protection fault and the dominance of the invalid flag all fall inside ordinary address values.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef struct packed {
    logic invalid;
    logic limit;
    logic prot;
  } xl_fault_t;

  function automatic logic any_fault(input xl_fault_t f);
    return f.invalid | f.limit | f.prot;
  endfunction

endpackage

// File: rtl/seg_wr_gate.sv
module seg_wr_gate (
  input  logic rst,
  input  logic wr_en,
  input  logic wr_priv,
  output logic wr_commit,
  output logic wr_denied
);

  always_comb begin
    wr_commit = wr_en & wr_priv & ~rst;
    wr_denied = wr_en & ~wr_priv;
  end

endmodule

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_W = 3,
  parameter int PA_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEG_W-1:0] w_idx,
  input  logic [PA_W-1:0]  w_base,
  input  logic [PA_W-1:0]  w_limit,
  input  logic             w_valid,
  input  logic             w_ronly,
  input  logic [SEG_W-1:0] r_idx,
  output logic [PA_W-1:0]  r_base,
  output logic [PA_W-1:0]  r_limit,
  output logic             r_valid,
  output logic             r_ronly
);

  localparam int NSEG = 1 << SEG_W;

  logic [PA_W-1:0] base_mem  [NSEG];
  logic [PA_W-1:0] limit_mem [NSEG];
  logic [NSEG-1:0] ronly_q;
  logic [NSEG-1:0] valid_q;

  // base/limit carry no reset so they map onto plain RAM
  always_ff @(posedge clk) begin
    if (we) begin
      base_mem[w_idx]  <= w_base;
      limit_mem[w_idx] <= w_limit;
      ronly_q[w_idx]   <= w_ronly;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (we) begin
      valid_q[w_idx] <= w_valid;
    end
  end

  always_comb begin
    r_base  = base_mem[r_idx];
    r_limit = limit_mem[r_idx];
    r_valid = valid_q[r_idx];
    r_ronly = ronly_q[r_idx];
  end

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 29,
  parameter int PA_W  = 32
) (
  input  logic [OFF_W-1:0] offset,
  input  logic             store,
  input  logic [PA_W-1:0]  base,
  input  logic [PA_W-1:0]  limit,
  input  logic             valid,
  input  logic             ronly,
  output logic [PA_W-1:0]  pa,
  output logic             ok,
  output xl_fault_t        fault
);

  logic [PA_W-1:0] off_ext;
  logic [PA_W-1:0] sum;

  generate
    if (PA_W > OFF_W) begin : g_pad
      assign off_ext = {{(PA_W-OFF_W){1'b0}}, offset};
    end else begin : g_trunc
      assign off_ext = offset[PA_W-1:0];
    end
  endgenerate

  always_comb begin
    sum           = base + off_ext;
    fault.invalid = ~valid;
    fault.limit   = valid & (off_ext > limit);
    fault.prot    = valid & store & ronly;
    ok            = ~any_fault(fault);
    pa            = ok ? sum : '0;
  end

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int SEG_W = 3,
  parameter int PA_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_priv,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [PA_W-1:0]  wr_limit,
  input  logic             wr_valid,
  input  logic             wr_ronly,
  output logic             wr_denied,
  input  logic [VA_W-1:0]  xl_va,
  input  logic             xl_store,
  output logic [PA_W-1:0]  pa,
  output logic             pa_ok,
  output logic             err_limit,
  output logic             err_invalid,
  output logic             err_prot
);

  localparam int OFF_W = VA_W - SEG_W;

  logic             commit;
  logic [SEG_W-1:0] sel;
  logic [OFF_W-1:0] offset;
  logic [PA_W-1:0]  t_base;
  logic [PA_W-1:0]  t_limit;
  logic             t_valid;
  logic             t_ronly;
  xl_fault_t        fault;

  assign sel    = xl_va[VA_W-1 -: SEG_W];
  assign offset = xl_va[OFF_W-1:0];

  seg_wr_gate gate_i (
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_priv   (wr_priv),
    .wr_commit (commit),
    .wr_denied (wr_denied)
  );

  seg_table #(.SEG_W(SEG_W), .PA_W(PA_W)) table_i (
    .clk     (clk),
    .rst     (rst),
    .we      (commit),
    .w_idx   (wr_idx),
    .w_base  (wr_base),
    .w_limit (wr_limit),
    .w_valid (wr_valid),
    .w_ronly (wr_ronly),
    .r_idx   (sel),
    .r_base  (t_base),
    .r_limit (t_limit),
    .r_valid (t_valid),
    .r_ronly (t_ronly)
  );

  seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) check_i (
    .offset (offset),
    .store  (xl_store),
    .base   (t_base),
    .limit  (t_limit),
    .valid  (t_valid),
    .ronly  (t_ronly),
    .pa     (pa),
    .ok     (pa_ok),
    .fault  (fault)
  );

  assign err_invalid = fault.invalid;
  assign err_limit   = fault.limit;
  assign err_prot    = fault.prot;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic            wr_priv,
  input logic            wr_denied,
  input logic            xl_store,
  input logic [PA_W-1:0] pa,
  input logic            pa_ok,
  input logic            err_limit,
  input logic            err_invalid,
  input logic            err_prot
);

  // R1: the cycle after reset sees only invalid descriptors
  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> err_invalid);

  // R3: a good translation carries no fault flag
  assert_ok_excludes_faults_R3: assert property (@(posedge clk) disable iff (rst)
    pa_ok |-> !(err_limit || err_invalid || err_prot));

  // R4: invalid segment masks the other faults
  assert_invalid_wins_R4: assert property (@(posedge clk) disable iff (rst)
    err_invalid |-> (!err_limit && !err_prot && !pa_ok));

  // R5: protection fault only on stores
  assert_prot_on_store_R5: assert property (@(posedge clk) disable iff (rst)
    err_prot |-> xl_store);

  // R7: unprivileged write is flagged
  assert_user_denied_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_priv) |-> wr_denied);

  // R8: no address leaves on a fault
  assert_zero_pa_R8: assert property (@(posedge clk) disable iff (rst)
    !pa_ok |-> (pa == '0));

endmodule

bind seg_xlate_top seg_xlate_chk #(.PA_W(PA_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_priv     (wr_priv),
  .wr_denied   (wr_denied),
  .xl_store    (xl_store),
  .pa          (pa),
  .pa_ok       (pa_ok),
  .err_limit   (err_limit),
  .err_invalid (err_invalid),
  .err_prot    (err_prot)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_priv = 1'b0, wr_valid = 1'b0, wr_ronly = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_base = '0, wr_limit = '0;
  logic        wr_denied;
  logic [31:0] xl_va = '0;
  logic        xl_store = 1'b0;
  logic [31:0] pa;
  logic        pa_ok, err_limit, err_invalid, err_prot;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_base [8];
  logic [31:0] m_lim  [8];
  bit          m_v    [8];
  bit          m_ro   [8];

  always #2 clk = ~clk;

  seg_xlate_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_priv(wr_priv), .wr_idx(wr_idx),
    .wr_base(wr_base), .wr_limit(wr_limit), .wr_valid(wr_valid), .wr_ronly(wr_ronly),
    .wr_denied(wr_denied), .xl_va(xl_va), .xl_store(xl_store), .pa(pa), .pa_ok(pa_ok),
    .err_limit(err_limit), .err_invalid(err_invalid), .err_prot(err_prot)
  );

  task automatic set_wr(bit en, bit priv, int idx, logic [31:0] b, logic [31:0] l, bit v, bit ro);
    wr_en = en; wr_priv = priv; wr_idx = idx[2:0];
    wr_base = b; wr_limit = l; wr_valid = v; wr_ronly = ro;
  endtask

  task automatic set_xl(int seg, logic [28:0] off, bit st);
    xl_va = {seg[2:0], off};
    xl_store = st;
  endtask

  // compare mid-cycle, then advance one clock and update the model
  task automatic step(string tag);
    logic [2:0]  s;
    logic [31:0] off, e_pa;
    bit e_inv, e_lim, e_prot, e_ok, e_den;
    #1;
    s = xl_va[31:29];
    off = {3'b000, xl_va[28:0]};
    e_inv = !m_v[s];
    e_lim = m_v[s] && (off > m_lim[s]);
    e_prot = m_v[s] && xl_store && m_ro[s];
    e_ok = !(e_inv || e_lim || e_prot);
    e_pa = e_ok ? m_base[s] + off : 32'h0;
    e_den = wr_en && !wr_priv;
    n_chk++;
    if ({pa, pa_ok, err_limit, err_invalid, err_prot, wr_denied} !==
        {e_pa, e_ok, e_lim, e_inv, e_prot, e_den}) begin
      n_bad++;
      $display("FAIL %s: got pa=%h ok=%b lim=%b inv=%b prot=%b den=%b exp pa=%h ok=%b lim=%b inv=%b prot=%b den=%b",
               tag, pa, pa_ok, err_limit, err_invalid, err_prot, wr_denied,
               e_pa, e_ok, e_lim, e_inv, e_prot, e_den);
    end
    @(posedge clk);
    if (wr_en && wr_priv && !rst) begin
      m_base[wr_idx] = wr_base; m_lim[wr_idx] = wr_limit;
      m_v[wr_idx] = wr_valid;   m_ro[wr_idx] = wr_ronly;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #400000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_base[i] = '0; m_lim[i] = '0; m_v[i] = 1'b0; m_ro[i] = 1'b0;
    end
    // R1: a write during reset must be dropped
    set_wr(1, 1, 3, 32'h100, 32'hFFFF, 1, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    wr_en = 1'b0;
    for (int i = 0; i < 8; i++) begin
      set_xl(i, 29'h5, 0);
      step("R1 reset invalid");
    end

    // R6: write seg 2, same-cycle lookup sees the old (invalid) entry
    set_wr(1, 1, 2, 32'h4000_0000, 32'h0000_0FFF, 1, 0);
    set_xl(2, 29'h10, 0);
    step("R6 same-cycle old contents");
    set_xl(2, 29'h10, 0);
    step("R2 base plus offset");
    set_xl(2, 29'hFFF, 1);
    step("R3 offset equal limit");
    set_xl(2, 29'h1000, 0);
    step("R3 R8 offset past limit");

    // R5: read-only segment
    set_wr(1, 1, 5, 32'h0000_1000, 32'h1FFF_FFFF, 1, 1);
    step("R6 write seg5");
    set_xl(5, 29'h1234, 0);
    step("R5 load from read-only");
    set_xl(5, 29'h1234, 1);
    step("R5 store to read-only");

    set_wr(1, 1, 6, 32'h2000, 32'h10, 1, 1);
    step("R6 write seg6");
    set_xl(6, 29'h20, 1);
    step("R5 R3 both faults");

    // R4: invalid masks the rest
    set_wr(1, 1, 6, 32'h2000, 32'h10, 0, 1);
    step("R6 invalidate seg6");
    set_xl(6, 29'h20, 1);
    step("R4 invalid wins");

    // R7: unprivileged write refused
    set_wr(1, 0, 2, 32'h7777_0000, 32'hFFFF, 1, 1);
    set_xl(2, 29'h10, 1);
    step("R7 denied flag");
    set_xl(2, 29'h10, 1);
    step("R7 table unchanged");

    // R9: wraparound
    set_wr(1, 1, 7, 32'hFFFF_FFF0, 32'h1FFF_FFFF, 1, 0);
    step("R6 write seg7");
    set_xl(7, 29'h20, 0);
    step("R9 sum wraps");

    // mixed random traffic
    for (int k = 0; k < 300; k++) begin
      set_wr(($urandom % 3) == 0, ($urandom % 4) != 0, $urandom % 8,
             $urandom, $urandom % 32'h0100_0000, ($urandom % 5) != 0, $urandom % 2);
      set_xl($urandom % 8, ($urandom % 2) ? 29'($urandom % 32'h0100_0000) : 29'($urandom), $urandom % 2);
      step("R2 random traffic");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule